// File: doc/BRIEF.md
# Hardware Cursor Overlay

This block places a small pointer image on top of a video pixel stream. A timing generator supplies the beam position and an active-display flag. Each pixel cycle the block either passes the background colour through or puts in one of three cursor colours. The result appears on the output one clock after the beam position that produced it.

The cursor image is 32 pixels wide and up to 32 rasters tall. It is held as 2-bit codes: code 0 is see-through and codes 1 to 3 pick one of three 12-bit RGB colour registers. Software loads the image one 32-bit word at a time, two words per raster. It sets the position, the height and the colours through a small register port.

Position and height writes are held in a pending copy. That copy is moved into the live copy at the next frame start, so a cursor never tears in the middle of a frame. Colour writes and image writes take effect at once.

Top module: `cursor_overlay`

## Requirements
- R1: While reset is low, `pix_out` is 0. After reset, the live and pending position, height and colour registers are all 0, so no cursor is drawn until a height is loaded.
- R2: `pix_out` is registered. For beam inputs sampled at one rising edge, the result appears after that same edge. Where no cursor pixel is drawn, it equals `bg_pixel` as sampled at that edge.
- R3: A cursor pixel with code 0 lets the background through. Codes 1, 2 and 3 substitute the colour registers written with select 3, 4 and 5 respectively.
- R4: Bitmap word address = raster × 2 + (column / 16). Cursor column c uses bits [2·(c mod 16)+1 : 2·(c mod 16)] of that word.
- R5: A beam position is inside the cursor when 0 ≤ x − hstart < 32 and 0 ≤ y − vstart < height. Here column = x − hstart and raster = y − vstart.
- R6: A height above 32 acts as 32. A height of 0 hides the cursor.
- R7: While `beam_active` is low, the output is the background, whatever the cursor state. The cursor is thereby clipped to the active display.
- R8: Writes to hstart, vstart and height change only the pending copy. It is copied to the live copy on a cycle with `frame_start` high. A write made in that same cycle waits for the following frame start.
- R9: A colour register write changes the colour used for the pixel computed at the next rising edge.
- R10: A bitmap write is seen by lookups from the next cycle on. A lookup in the same cycle as the write sees the old word.
- R11: Register select encoding: 0 = hstart (low 11 data bits), 1 = vstart (low 10 bits), 2 = height (low 6 bits), 3/4/5 = colour 1/2/3 (low 12 bits, red in [11:8], green in [7:4], blue in [3:0]). Selects 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| beam_x | input | 11 | Current beam column |
| beam_y | input | 10 | Current beam raster |
| beam_active | input | 1 | High inside the active display |
| frame_start | input | 1 | One-cycle pulse at the start of a frame |
| bg_pixel | input | 12 | Background RGB colour for this pixel |
| bm_we | input | 1 | Bitmap word write enable |
| bm_addr | input | 6 | Bitmap word address (raster × 2 + half) |
| bm_data | input | 32 | Bitmap word, 16 two-bit codes |
| reg_we | input | 1 | Register write enable |
| reg_sel | input | 3 | Register select |
| reg_data | input | 16 | Register write data |
| pix_out | output | 12 | Output RGB pixel, one cycle after the beam inputs |

## Verification
Two pairs of events can fall in the same cycle. A position write can arrive on the very cycle of a frame start. A bitmap write can target the word that the beam is reading. The bench forces both on purpose. It writes hstart in the frame-start cycle, then checks that the cursor stays put for that whole frame and moves only in the frame after. It also rewrites a displayed word exactly when the beam reads it. The cycle-by-cycle reference model then expects the old pattern on that pixel and the new one on later pixels.

// File: rtl/cursor_pkg.sv
// Shared types for the cursor overlay.
// Assumes colours are 12-bit RGB with 4 bits per channel.
package cursor_pkg;
    localparam int RGB_W = 12;

    typedef logic [RGB_W-1:0] rgb12_t;
    typedef logic [1:0]       cur_code_t;

    typedef enum logic [2:0] {
        SEL_HSTART = 3'd0,
        SEL_VSTART = 3'd1,
        SEL_HEIGHT = 3'd2,
        SEL_COL1   = 3'd3,
        SEL_COL2   = 3'd4,
        SEL_COL3   = 3'd5
    } reg_sel_e;
endpackage

// File: rtl/cursor_regs.sv
// Cursor control registers.
// Position and height have a pending copy and a live copy; the live copy
// loads on frame_start. Colours load at once. Height is clamped to MAX_H
// as it enters the live copy. Assumes X_W and Y_W are at most 16.
module cursor_regs
    import cursor_pkg::*;
#(
    parameter int X_W   = 11,
    parameter int Y_W   = 10,
    parameter int MAX_H = 32,
    parameter int H_W   = $clog2(MAX_H) + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [2:0]     reg_sel,
    input  logic [15:0]    reg_data,
    input  logic           frame_start,
    output logic [X_W-1:0] live_hs,
    output logic [Y_W-1:0] live_vs,
    output logic [H_W-1:0] live_ht,
    output rgb12_t         col1,
    output rgb12_t         col2,
    output rgb12_t         col3
);
    localparam logic [H_W-1:0] HT_CAP = H_W'(MAX_H);

    logic [X_W-1:0] pend_hs;
    logic [Y_W-1:0] pend_vs;
    logic [H_W-1:0] pend_ht;

    // Pending copy: captures position and height writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_hs <= '0;
            pend_vs <= '0;
            pend_ht <= '0;
        end else if (reg_we) begin
            case (reg_sel)
                SEL_HSTART: pend_hs <= reg_data[X_W-1:0];
                SEL_VSTART: pend_vs <= reg_data[Y_W-1:0];
                SEL_HEIGHT: pend_ht <= reg_data[H_W-1:0];
                default: ;
            endcase
        end
    end

    // Live copy: takes the pending values at each frame start, height clamped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_hs <= '0;
            live_vs <= '0;
            live_ht <= '0;
        end else if (frame_start) begin
            live_hs <= pend_hs;
            live_vs <= pend_vs;
            live_ht <= (pend_ht > HT_CAP) ? HT_CAP : pend_ht;
        end
    end

    // Colour registers: written directly, used from the next edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col1 <= '0;
            col2 <= '0;
            col3 <= '0;
        end else if (reg_we) begin
            case (reg_sel)
                SEL_COL1: col1 <= reg_data[RGB_W-1:0];
                SEL_COL2: col2 <= reg_data[RGB_W-1:0];
                SEL_COL3: col3 <= reg_data[RGB_W-1:0];
                default: ;
            endcase
        end
    end

    // R8: live position only moves on the edge after a frame_start cycle
    assert_live_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(live_hs) && $stable(live_vs) && $stable(live_ht)));

    // R6: live height never exceeds the cap
    assert_height_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        live_ht <= HT_CAP);
endmodule

// File: rtl/cursor_bitmap.sv
// Cursor image store: MAX_H rasters of CUR_W two-bit codes, packed in
// WORD_W-bit words. Writes are synchronous. The read is combinational, so
// a read in the same cycle as a write returns the old word.
module cursor_bitmap
    import cursor_pkg::*;
#(
    parameter int CUR_W  = 32,
    parameter int MAX_H  = 32,
    parameter int WORD_W = 32,
    parameter int ROW_W  = $clog2(MAX_H),
    parameter int COL_W  = $clog2(CUR_W),
    parameter int ADDR_W = $clog2(MAX_H * 2 * CUR_W / WORD_W)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ROW_W-1:0]  rd_row,
    input  logic [COL_W-1:0]  rd_col,
    output cur_code_t         rd_code
);
    localparam int PIX_PER_WORD = WORD_W / 2;
    localparam int WORDS_PER_ROW = CUR_W / PIX_PER_WORD;
    localparam int DEPTH = MAX_H * WORDS_PER_ROW;
    localparam int SUB_W = $clog2(PIX_PER_WORD);
    localparam int HALF_W = (WORDS_PER_ROW > 1) ? $clog2(WORDS_PER_ROW) : 1;

    logic [WORD_W-1:0] mem [DEPTH];

    // One write-enabled register per stored word.
    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (wr_en && (wr_addr == ADDR_W'(i)))
                mem[i] <= wr_data;
        end
    end

    logic [HALF_W-1:0] half_sel;
    logic [ADDR_W-1:0] rd_addr;
    logic [SUB_W-1:0]  sub_pix;
    logic [WORD_W-1:0] rd_word;

    // Locate the word and the bit pair for (row, col).
    always_comb begin
        half_sel = HALF_W'(rd_col >> SUB_W);
        sub_pix  = rd_col[SUB_W-1:0];
        rd_addr  = ADDR_W'(rd_row * WORDS_PER_ROW) + ADDR_W'(half_sel);
        rd_word  = mem[rd_addr];
        rd_code  = rd_word[2*sub_pix +: 2];
    end
endmodule

// File: rtl/cursor_mixer.sv
// Output stage: picks the background or a cursor colour and registers it.
// Assumes 'hit' already includes the active-display and window tests.
module cursor_mixer
    import cursor_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hit,
    input  cur_code_t code,
    input  rgb12_t    bg,
    input  rgb12_t    col1,
    input  rgb12_t    col2,
    input  rgb12_t    col3,
    output rgb12_t    pix_out
);
    rgb12_t   next_pix;
    logic [2:0] use_col;

    // Decode which colour register, if any, replaces the background.
    always_comb begin
        use_col = 3'b000;
        if (hit) begin
            case (code)
                2'd1: use_col = 3'b001;
                2'd2: use_col = 3'b010;
                2'd3: use_col = 3'b100;
                default: use_col = 3'b000;
            endcase
        end
        unique case (1'b1)
            use_col[0]: next_pix = col1;
            use_col[1]: next_pix = col2;
            use_col[2]: next_pix = col3;
            default:    next_pix = bg;
        endcase
    end

    // Output register: fixes the latency at one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) pix_out <= '0;
        else        pix_out <= next_pix;
    end

    // R3: code zero is see-through
    assert_transparent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && code == 2'd0) |=> pix_out == $past(bg));

    // R3: at most one colour register is chosen
    assert_one_colour_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(use_col));
endmodule

// File: rtl/cursor_overlay.sv
// Hardware cursor overlay top.
// Tests the beam against the live cursor window, looks up the 2-bit code
// and mixes the cursor over the background with a one-cycle latency.
// Assumes beam_x/beam_y come from a timing generator that also supplies
// beam_active and a one-cycle frame_start pulse.
module cursor_overlay
    import cursor_pkg::*;
#(
    parameter int X_W    = 11,
    parameter int Y_W    = 10,
    parameter int CUR_W  = 32,
    parameter int MAX_H  = 32,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [X_W-1:0]    beam_x,
    input  logic [Y_W-1:0]    beam_y,
    input  logic              beam_active,
    input  logic              frame_start,
    input  logic [RGB_W-1:0]  bg_pixel,
    input  logic              bm_we,
    input  logic [5:0]        bm_addr,
    input  logic [WORD_W-1:0] bm_data,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [15:0]       reg_data,
    output logic [RGB_W-1:0]  pix_out
);
    localparam int H_W    = $clog2(MAX_H) + 1;
    localparam int ROW_W  = $clog2(MAX_H);
    localparam int COL_W  = $clog2(CUR_W);
    localparam int ADDR_W = $clog2(MAX_H * 2 * CUR_W / WORD_W);
    localparam logic [X_W-1:0] WIN_W = X_W'(CUR_W);

    logic [X_W-1:0] live_hs;
    logic [Y_W-1:0] live_vs;
    logic [H_W-1:0] live_ht;
    rgb12_t         col1, col2, col3;

    cursor_regs #(.X_W(X_W), .Y_W(Y_W), .MAX_H(MAX_H), .H_W(H_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_data(reg_data),
        .frame_start(frame_start),
        .live_hs(live_hs), .live_vs(live_vs), .live_ht(live_ht),
        .col1(col1), .col2(col2), .col3(col3)
    );

    logic [X_W-1:0] dx;
    logic [Y_W-1:0] dy;
    logic           hit;

    // Window test: offset of the beam from the cursor origin, clipped to active.
    always_comb begin
        dx  = beam_x - live_hs;
        dy  = beam_y - live_vs;
        hit = beam_active
            && (beam_x >= live_hs) && (dx < WIN_W)
            && (beam_y >= live_vs) && (dy < Y_W'(live_ht));
    end

    cur_code_t code;

    cursor_bitmap #(.CUR_W(CUR_W), .MAX_H(MAX_H), .WORD_W(WORD_W),
                    .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)) u_bitmap (
        .clk(clk),
        .wr_en(bm_we), .wr_addr(bm_addr[ADDR_W-1:0]), .wr_data(bm_data),
        .rd_row(dy[ROW_W-1:0]), .rd_col(dx[COL_W-1:0]),
        .rd_code(code)
    );

    cursor_mixer u_mix (
        .clk(clk), .rst_n(rst_n),
        .hit(hit), .code(code), .bg(bg_pixel),
        .col1(col1), .col2(col2), .col3(col3),
        .pix_out(pix_out)
    );

    // R7: outside the active display the background always passes
    assert_clip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !beam_active |=> pix_out == $past(bg_pixel));

    // R6: a zero live height never draws the cursor
    assert_zero_height_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (live_ht == '0) |=> pix_out == $past(bg_pixel));
endmodule

// File: tb/cursor_overlay_test.sv
module cursor_overlay_test;
    localparam int HTOT = 72, VTOT = 44, HACT = 64, VACT = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] beam_x = '0;
    logic [9:0]  beam_y = '0;
    logic        beam_active = 1'b0;
    logic        frame_start = 1'b0;
    logic [11:0] bg_pixel = '0;
    logic        bm_we = 1'b0;
    logic [5:0]  bm_addr = '0;
    logic [31:0] bm_data = '0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [15:0] reg_data = '0;
    logic [11:0] pix_out;

    always #2.5 clk = ~clk;

    cursor_overlay uut (
        .clk(clk), .rst_n(rst_n), .beam_x(beam_x), .beam_y(beam_y),
        .beam_active(beam_active), .frame_start(frame_start), .bg_pixel(bg_pixel),
        .bm_we(bm_we), .bm_addr(bm_addr), .bm_data(bm_data),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_data(reg_data),
        .pix_out(pix_out)
    );

    int compared = 0;
    int mismatched = 0;

    // Reference model state
    int p_hs = 0, p_vs = 0, p_ht = 0;
    int a_hs = 0, a_vs = 0, a_ht = 0;
    int col [4] = '{0, 0, 0, 0};
    logic [31:0] bm [64];

    logic [11:0] exp_pix;
    bit          exp_valid = 0;
    string       exp_tag;

    function automatic logic [31:0] pattern(int a);
        return 32'hA5C3_961E ^ (32'(a) * 32'h9E37_79B1);
    endfunction

    task automatic check(logic [11:0] got, logic [11:0] want, string tag);
        compared++;
        if (got !== want) begin
            mismatched++;
            $display("FAIL %s: pix_out=%h expected %h", tag, got, want);
        end
    endtask

    // One pixel cycle: compare last result, drive new inputs, predict, update model.
    task automatic cycle(bit fs, bit act, int x, int y, int bg,
                         bit bwe, int baddr, logic [31:0] bdata,
                         bit rwe, int rsel, int rdata, string phase);
        int dx, dy, h, code;
        logic [31:0] w;
        string kind;
        @(negedge clk);
        if (exp_valid) check(pix_out, exp_pix, exp_tag);
        frame_start = fs; beam_active = act;
        beam_x = 11'(x); beam_y = 10'(y); bg_pixel = 12'(bg);
        bm_we = bwe; bm_addr = 6'(baddr); bm_data = bdata;
        reg_we = rwe; reg_sel = 3'(rsel); reg_data = 16'(rdata);
        exp_pix = 12'(bg);
        if (!act) kind = "R7 clipped";
        else begin
            kind = "R2 background";
            dx = x - a_hs; dy = y - a_vs;
            h = (a_ht > 32) ? 32 : a_ht;           // R6 clamp
            if (dx >= 0 && dx < 32 && dy >= 0 && dy < h) begin   // R5 window
                w = bm[dy*2 + dx/16];                // R4 word/bit mapping
                code = int'((w >> (2*(dx%16))) & 32'd3);
                if (code != 0) begin
                    exp_pix = 12'(col[code]);
                    kind = "R3 colour";
                end else kind = "R3 transparent";
            end
        end
        exp_tag = {phase, " ", kind};
        exp_valid = 1;
        if (fs) begin a_hs = p_hs; a_vs = p_vs; a_ht = p_ht; end
        if (rwe) begin
            case (rsel)
                0: p_hs = rdata & 16'h7FF;
                1: p_vs = rdata & 16'h3FF;
                2: p_ht = rdata & 16'h3F;
                3, 4, 5: col[rsel-2] = rdata & 16'hFFF;
                default: ;
            endcase
        end
        if (bwe) bm[baddr] = bdata;
    endtask

    task automatic wr_reg(int sel, int data, string phase);
        cycle(0, 0, 0, 0, 0, 0, 0, '0, 1, sel, data, phase);
    endtask

    task automatic run_frame(string phase, int fr, int rw_at, int rsel, int rdata,
                             int bw_at, int baddr, logic [31:0] bdata);
        for (int y = 0; y < VTOT; y++) begin
            for (int x = 0; x < HTOT; x++) begin
                int idx = y*HTOT + x;
                cycle(idx == 0, (x < HACT) && (y < VACT), x, y,
                      (x*7 + y*13 + fr*29) & 12'hFFF,
                      idx == bw_at, baddr, bdata,
                      idx == rw_at, rsel, rdata, phase);
            end
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin : main
        bg_pixel = 12'h5A5;
        beam_active = 1'b1;
        // R1: output held at zero during reset
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (i > 0) check(pix_out, 12'h000, "R1 reset");
        end
        @(negedge clk);
        rst_n = 1'b1;
        // R1: after reset, height 0 means pure pass-through
        for (int i = 0; i < 20; i++)
            cycle(i == 5, 1, i, 0, 12'h100 + i, 0, 0, '0, 0, 0, 0, "R1");
        // R4: load the image
        for (int a = 0; a < 64; a++)
            cycle(0, 0, 0, 0, a, 1, a, pattern(a), 0, 0, 0, "R4");
        // R11: colours, position, height, plus ignored selects 6 and 7
        wr_reg(3, 16'hFF00 | 12'hF00, "R11");
        wr_reg(4, 12'h0F0, "R11");
        wr_reg(5, 12'h00F, "R11");
        wr_reg(0, 10, "R11");
        wr_reg(1, 5, "R11");
        wr_reg(2, 8, "R11");
        wr_reg(6, 16'hFFFF, "R11 unused");
        wr_reg(7, 16'h1234, "R11 unused");
        // R8: no frame start yet, cursor region shows background
        for (int i = 0; i < 30; i++)
            cycle(0, 1, 8 + i, 7, 12'h321 + i, 0, 0, '0, 0, 0, 0, "R8 pending");
        run_frame("R5", 1, -1, 0, 0, -1, 0, '0);
        // R6/R7: oversize height and a cursor hanging off the active area
        wr_reg(0, 50, "R7");
        wr_reg(1, 30, "R7");
        wr_reg(2, 40, "R6");
        run_frame("R6/R7 clamp+clip", 2, -1, 0, 0, -1, 0, '0);
        wr_reg(2, 0, "R6");
        run_frame("R6 zero height", 3, -1, 0, 0, -1, 0, '0);
        wr_reg(0, 10, "R3");
        wr_reg(1, 5, "R3");
        wr_reg(2, 8, "R3");
        run_frame("R3", 4, -1, 0, 0, -1, 0, '0);
        // R9: colour change in the middle of the cursor
        run_frame("R9", 5, 6*HTOT + 20, 4, 12'hABC, -1, 0, '0);
        // R8 + R10: hstart write on the frame-start cycle, bitmap write on a live read
        run_frame("R8/R10 collide", 6, 0, 0, 20, 7*HTOT + 12, 4, 32'hFFFF_FFFF);
        run_frame("R8 moved", 7, -1, 0, 0, -1, 0, '0);
        cycle(0, 0, 0, 0, 0, 0, 0, '0, 0, 0, 0, "R2 tail");
        @(negedge clk);
        check(pix_out, exp_pix, exp_tag);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule